// File: doc/BRIEF.md
# Two-Rail Display Supply Sequencer

This block switches the enables of two supplies feeding a tiled display, a logic rail and a display rail, in a safe order. It also drives a heater (filament) enable. Two tile variants need opposite orders. On a display-first tile the display rail leads at power-up. On a logic-first tile the logic rail leads. At power-down the order is mirrored, so the leading rail is always the last to go off. The time between the two rail edges comes from a gap input in clock cycles. That gap is held below a hard maximum, and a fault flag reports any request at or above that maximum.

The heater enable turns on with the first rail and turns off with the last one. A ready flag tells downstream logic that the display can be used. It rises only after both rails are on and a warm-up interval has passed since the second rail came on. A change of the power request in the middle of a sequence never cuts a step short: the step in progress finishes, and then the sequencer reverses. Variant and gap are captured when a sequence starts, so later changes on those inputs cannot reorder a sequence that is running.

States: `ST_OFF` (all enables low), `ST_LEAD_UP` (leading rail on, counting the gap), `ST_WARM` (both rails on, counting the warm-up), `ST_READY` (ready high), `ST_LEAD_DN` (trailing rail off, counting the gap). Transitions:
- `ST_OFF`→`ST_LEAD_UP` on request with a non-zero gap, or `ST_OFF`→`ST_WARM` on request with a zero gap.
- `ST_LEAD_UP`→`ST_WARM` when the gap expires.
- `ST_WARM`→`ST_READY` when the warm-up expires.
- From `ST_WARM` or `ST_READY`: to `ST_LEAD_DN` when the request drops with a non-zero gap, or to `ST_OFF` when it drops with a zero gap.
- `ST_LEAD_DN`→`ST_OFF` when the gap expires.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is low, and on the first edge after it is released, logic_en, disp_en, fil_en, ready and fault are all 0. Reset in the middle of a sequence drops every enable at the next edge.
- R2: With variant_sel=0 (display-first), disp_en rises at the first clock edge that samples pwr_req=1. logic_en rises exactly G edges later, where G is the effective gap.
- R3: With variant_sel=1 (logic-first), logic_en rises at the first edge that samples pwr_req=1. disp_en rises exactly G edges later.
- R4: With an effective gap of 0, both rails rise at the same edge at power-up and fall at the same edge at power-down.
- R5: For variant 0, logic_en falls at the first edge that samples pwr_req=0. disp_en and fil_en fall G edges later.
- R6: For variant 1, disp_en falls at the first edge that samples pwr_req=0. logic_en and fil_en fall G edges later.
- R7: The effective gap is gap_cfg when gap_cfg < MAX_GAP, and MAX_GAP-1 otherwise. fault is 1 one edge after gap_cfg >= MAX_GAP is sampled, and 0 one edge after gap_cfg < MAX_GAP is sampled.
- R8: ready rises WARM_CYCLES edges after the edge at which the second rail turned on. It is only ever 1 while both rails and fil_en are 1, and it falls at the edge that begins power-down.
- R9: If the request drops during the up gap, the second rail still turns on at its scheduled edge, and power-down starts at the next edge. If the request returns during the down gap, the last rail still turns off at its scheduled edge, and power-up starts at the next edge.
- R10: variant_sel is captured when power-up starts. The gap is captured when each power-up or power-down starts. Changes on these inputs during a sequence have no effect on it.
- R11: fil_en is 1 exactly when at least one rail enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | 1 requests the display powered, 0 requests it off |
| variant_sel | input | 1 | 0 = display-first tile, 1 = logic-first tile |
| gap_cfg | input | GAP_W | Requested inter-rail gap in clock cycles |
| logic_en | output | 1 | Logic rail enable |
| disp_en | output | 1 | Display rail enable |
| fil_en | output | 1 | Heater (filament) enable |
| ready | output | 1 | Both rails on and warm-up complete |
| fault | output | 1 | Requested gap is at or above MAX_GAP |

## Verification
The enables and the ready flag are decoded straight from the state register. Each of them therefore changes at the edge that samples the request, then G edges later, then WARM_CYCLES edges after that. The fault flag follows gap_cfg by exactly one edge. The bench drives inputs and samples outputs one time unit after each rising edge. It counts edges from the edge that first samples a new request and compares every enable at every counted edge against the expected pattern. This pins each transition to its exact cycle rather than only checking the final state.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_LEAD_UP,
        ST_WARM,
        ST_READY,
        ST_LEAD_DN
    } seq_state_e;
endpackage

// File: rtl/gap_limit.sv
module gap_limit #(
    parameter int GAP_W   = 8,
    parameter int MAX_GAP = 200
) (
    input  logic [GAP_W-1:0] gap_cfg,
    output logic [GAP_W-1:0] gap_eff,
    output logic             over
);
    localparam logic [31:0] MAX_U = MAX_GAP;

    // Requests at or above the bound are clamped just below it (R7)
    always_comb begin
        over    = (32'(gap_cfg) >= MAX_U);
        gap_eff = over ? GAP_W'(MAX_GAP - 1) : gap_cfg;
    end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Saturating up-counter, cleared on every state change
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt != CNT_W'(LIMIT))
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import pwrseq_pkg::*;
#(
    parameter int GAP_W       = 8,
    parameter int MAX_GAP     = 200,
    parameter int WARM_CYCLES = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_req,
    input  logic             variant_sel,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             logic_en,
    output logic             disp_en,
    output logic             fil_en,
    output logic             ready,
    output logic             fault
);
    localparam int LIMIT = (MAX_GAP > WARM_CYCLES) ? MAX_GAP : WARM_CYCLES;
    localparam int CNT_W = $clog2(LIMIT + 1);

    seq_state_e       state_q, state_d;
    logic             var_q;
    logic [GAP_W-1:0] gap_q;
    logic             fault_q;
    logic [GAP_W-1:0] gap_eff;
    logic             gap_over;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] gap_last;
    logic [CNT_W-1:0] warm_last;
    logic             start_up, start_dn;

    gap_limit #(.GAP_W(GAP_W), .MAX_GAP(MAX_GAP)) u_gap_limit (
        .gap_cfg (gap_cfg),
        .gap_eff (gap_eff),
        .over    (gap_over)
    );

    seq_timer #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_seq_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (cnt)
    );

    assign gap_last  = CNT_W'(gap_q) - CNT_W'(1);
    assign warm_last = CNT_W'(WARM_CYCLES - 1);
    assign start_up  = (state_q == ST_OFF) && pwr_req;
    assign start_dn  = ((state_q == ST_WARM) || (state_q == ST_READY)) && !pwr_req;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (pwr_req) state_d = (gap_eff == '0) ? ST_WARM : ST_LEAD_UP;
            ST_LEAD_UP: if (cnt == gap_last) state_d = ST_WARM;
            ST_WARM: begin
                if (!pwr_req)              state_d = (gap_eff == '0) ? ST_OFF : ST_LEAD_DN;
                else if (cnt == warm_last) state_d = ST_READY;
            end
            ST_READY:   if (!pwr_req) state_d = (gap_eff == '0) ? ST_OFF : ST_LEAD_DN;
            ST_LEAD_DN: if (cnt == gap_last) state_d = ST_OFF;
            default:    state_d = ST_OFF;
        endcase
    end

    // State register with captured variant and gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            var_q   <= 1'b0;
            gap_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= gap_over;
            if (start_up)             var_q <= variant_sel;
            if (start_up || start_dn) gap_q <= gap_eff;
        end
    end

    // Moore output decode: the leading rail is also the last one off
    always_comb begin
        logic lead, both;
        lead     = (state_q == ST_LEAD_UP) || (state_q == ST_LEAD_DN);
        both     = (state_q == ST_WARM) || (state_q == ST_READY);
        logic_en = both || (lead && var_q);
        disp_en  = both || (lead && !var_q);
        fil_en   = lead || both;
        ready    = (state_q == ST_READY);
        fault    = fault_q;
    end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int GAP_W   = 8,
    parameter int MAX_GAP = 200
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GAP_W-1:0] gap_cfg,
    input logic             var_q,
    input logic             logic_en,
    input logic             disp_en,
    input logic             fil_en,
    input logic             ready,
    input logic             fault
);
    localparam logic [31:0] MAX_U = MAX_GAP;

    AST_ORDER_DISP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!var_q && logic_en) |-> disp_en); // R2
    AST_ORDER_LOGIC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (var_q && disp_en) |-> logic_en); // R3
    AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(gap_cfg) >= MAX_U) |=> fault); // R7
    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(gap_cfg) < MAX_U) |=> !fault); // R7
    AST_READY_NEEDS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (logic_en && disp_en && fil_en)); // R8
    AST_READY_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(logic_en) && $past(disp_en))); // R8
    AST_FIL_TRACKS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        fil_en == (logic_en || disp_en)); // R11
    AST_VARIANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((logic_en || disp_en) && $past(logic_en || disp_en)) |-> $stable(var_q)); // R10
endmodule

bind rail_sequencer seq_checker #(.GAP_W(GAP_W), .MAX_GAP(MAX_GAP)) u_seq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .gap_cfg  (gap_cfg),
    .var_q    (var_q),
    .logic_en (logic_en),
    .disp_en  (disp_en),
    .fil_en   (fil_en),
    .ready    (ready),
    .fault    (fault)
);

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int GW   = 6;
    localparam int MAXG = 20;
    localparam int WARM = 12;

    typedef struct packed {
        logic       v;
        logic [7:0] cfg;
        logic [7:0] g;
        logic       f;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 8'd3,  8'd3,  1'b0},
        '{1'b1, 8'd3,  8'd3,  1'b0},
        '{1'b0, 8'd0,  8'd0,  1'b0},
        '{1'b1, 8'd0,  8'd0,  1'b0},
        '{1'b0, 8'd20, 8'd19, 1'b1},
        '{1'b1, 8'd25, 8'd19, 1'b1},
        '{1'b0, 8'd19, 8'd19, 1'b0},
        '{1'b1, 8'd1,  8'd1,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwr_req;
    logic          variant_sel;
    logic [GW-1:0] gap_cfg;
    logic          logic_en, disp_en, fil_en, ready, fault;

    int n_chk = 0;
    int n_bad = 0;

    rail_sequencer #(.GAP_W(GW), .MAX_GAP(MAXG), .WARM_CYCLES(WARM)) i_rail_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_req     (pwr_req),
        .variant_sel (variant_sel),
        .gap_cfg     (gap_cfg),
        .logic_en    (logic_en),
        .disp_en     (disp_en),
        .fil_en      (fil_en),
        .ready       (ready),
        .fault       (fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // {logic_en, disp_en, fil_en, ready}
    function automatic int pins();
        return int'({logic_en, disp_en, fil_en, ready});
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_up(logic v, int g, string tag);
        pwr_req = 1'b1;
        for (int k = 1; k <= g + WARM + 1; k++) begin
            logic l, d, r;
            step();
            l = v ? 1'b1 : (k >= g + 1);
            d = v ? (k >= g + 1) : 1'b1;
            r = (k >= g + 1 + WARM);
            chk(tag, pins(), int'({l, d, 1'b1, r}));
        end
    endtask

    task automatic run_dn(logic v, int g, string tag);
        pwr_req = 1'b0;
        for (int k = 1; k <= g + 1; k++) begin
            step();
            if (k >= g + 1) chk(tag, pins(), 0);
            else            chk(tag, pins(), v ? 4'b1010 : 4'b0110);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_req = 1'b0; variant_sel = 1'b0; gap_cfg = '0;
        repeat (3) step();
        chk("R1 reset outputs", pins(), 0);
        chk("R1 reset fault", int'(fault), 0);
        rst_n = 1'b1;
        step();
        chk("R1 first edge after reset", pins(), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R11
        foreach (VECS[i]) begin
            vec_t vv;
            string up_tag, dn_tag;
            vv = VECS[i];
            variant_sel = vv.v;
            gap_cfg     = GW'(vv.cfg);
            step();
            chk($sformatf("R7 fault vec%0d", i), int'(fault), int'(vv.f));
            up_tag = $sformatf("%s R8 R11 up vec%0d%s", vv.v ? "R3" : "R2", i,
                               (vv.g == 0) ? " R4" : (vv.f ? " R7" : ""));
            dn_tag = $sformatf("%s R11 down vec%0d%s", vv.v ? "R6" : "R5", i,
                               (vv.g == 0) ? " R4" : "");
            run_up(vv.v, int'(vv.g), up_tag);
            run_dn(vv.v, int'(vv.g), dn_tag);
        end

        // R9: request withdrawn during the up gap
        variant_sel = 1'b1; gap_cfg = GW'(4);
        step();
        pwr_req = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            step();
            if (k == 2) pwr_req = 1'b0;
            if (k == 5)       chk("R9 up completes", pins(), 4'b1110);
            else if (k == 10) chk("R9 reverse ends", pins(), 0);
            else              chk("R9 lead rail only", pins(), 4'b1010);
        end

        // R9: request returns during the down gap
        variant_sel = 1'b0; gap_cfg = GW'(3);
        step();
        run_up(1'b0, 3, "R9 pre-up");
        pwr_req = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            step();
            if (k == 1) pwr_req = 1'b1;
            if (k == 4) chk("R9 down completes", pins(), 0);
            else        chk("R9 display held", pins(), 4'b0110);
        end
        pwr_req = 1'b0;
        repeat (25) step();
        chk("R9 settles off", pins(), 0);

        // R10: variant and gap changes mid-sequence are ignored
        variant_sel = 1'b0; gap_cfg = GW'(5);
        step();
        pwr_req = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            step();
            if (k == 2) begin variant_sel = 1'b1; gap_cfg = GW'(1); end
            if (k == 6) chk("R10 up gap kept", pins(), 4'b1110);
            else        chk("R10 variant kept", pins(), 4'b0110);
        end
        pwr_req = 1'b0;
        step();
        chk("R10 down keeps variant", pins(), 4'b0110);
        step();
        chk("R10 down uses new gap", pins(), 0);

        // R1: reset in the middle of a sequence
        variant_sel = 1'b0; gap_cfg = GW'(2);
        pwr_req = 1'b1;
        repeat (4) step();
        chk("R1 pre-reset rails on", pins(), 4'b1110);
        rst_n = 1'b0;
        step();
        chk("R1 mid-sequence reset", pins(), 0);
        pwr_req = 1'b0;
        rst_n = 1'b1;
        step();
        chk("R1 after release", pins(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule